// File: doc/BRIEF.md
# Game Port Soft Switch Controller

This block serves one 256-byte I/O page of a small CPU system: the page that drives the game connector and the cassette port. A CPU access to certain addresses in the page changes output pins, and the address alone selects the action, so a read and a write have the same effect. Four lamp/relay style outputs are set or cleared by address pairs. One address fires a fixed-width active-low strobe. Another address flips the cassette output. A fifth address restarts four paddle timers.

Reads in the page return one status bit in bit 7 of the data byte. That bit can be the cassette input, one of three push buttons, or the state of one paddle timer. Each paddle is a digital one-shot: an 8-bit count input sets its length, and it counts down at a fixed tick rate. This replaces the capacitor-and-resistor timing of an analog paddle. Read data is combinational while the access is held. Every side effect of an access is taken at the clock edge that samples it.

Top module: `gameIoPage`

## Requirements
- R1: After reset, all four annunciator outputs are 0, `stbN` is 1, `cassOut` is 0, and every paddle reads as expired (bit 7 = 1).
- R2: An access to page offset 0x58+2n clears annunciator n and an access to 0x59+2n sets it (n = 0..3, so offset bits [2:1] pick the output and bit 0 the value). The change shows after the sampling edge, and the other annunciators keep their values.
- R3: An access to offset 0x40 drives `stbN` low from the sampling edge for STB_CYCLES clocks (the strobe width in ns divided by the clock period in ns and rounded to the nearest integer; 61 at an 8 ns clock). `stbN` then returns high. An access during the pulse restarts the full width.
- R4: Each access to offset 0x20, read or write, inverts `cassOut` at the sampling edge.
- R5: A read of offset 0x60 returns `cassIn` in bit 7.
- R6: Reads of offsets 0x61, 0x62 and 0x63 return `swIn[0]`, `swIn[1]` and `swIn[2]` in bit 7.
- R7: An access to offset 0x70 loads all four paddle timers from `padCount` (paddle i uses bits [8i+7:8i]). Reads of offsets 0x64+i then return bit 7 = 0 for exactly count*TICK_DIV clocks after the sampling edge, and 1 after that. A count of 0 never shows 0.
- R8: An access to offset 0x70 while the timers run reloads them with the present `padCount` and restarts the tick phase.
- R9: Bits 6..0 of `busRdata` are always 0. A write, an idle bus, or a read of an offset that is not mapped returns 0x00.
- R10: An access is ignored when `busEn` is low or the address high byte is not 0xC0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Access valid this cycle |
| busRw | input | 1 | 1 = read, 0 = write |
| busAddr | input | 16 | CPU address |
| busRdata | output | 8 | Read data, status in bit 7 |
| swIn | input | 3 | Push-button inputs |
| cassIn | input | 1 | Cassette input level |
| padCount | input | 32 | Four 8-bit paddle counts |
| annOut | output | 4 | Annunciator outputs |
| stbN | output | 1 | Active-low strobe |
| cassOut | output | 1 | Cassette output |

## Verification
Annunciator accesses use random offsets and random read/write direction, checked against a bench model, so a wrong index or a wrong polarity shows up. Paddle timers are loaded with random counts that include zero and large values, and the bench polls all four timers in rotation on every cycle. This catches an off-by-one at expiry or a timer that ignores its own count. Retriggers of the strobe and the paddles in mid-run tell a reload apart from a pulse that simply runs on. Accesses outside the page, with `busEn` low, and to unmapped offsets show that the decode is exact.

// File: rtl/gamePkg.sv
`timescale 1ns/1ps
package gamePkg;
  // Strobes from decode to datapath for one bus cycle
  typedef struct packed {
    logic       annWe;
    logic [1:0] annIdx;
    logic       annVal;
    logic       cassFlip;
    logic       stbFire;
    logic       padFire;
    logic       rdEn;
    logic [2:0] rdSel;  // 0 cassette, 1..3 buttons, 4..7 paddles
  } ctrlT;
endpackage

// File: rtl/gameDecode.sv
`timescale 1ns/1ps
module gameDecode
  import gamePkg::*;
#(
  parameter logic [7:0] PAGE = 8'hC0
) (
  input  logic        busEn,
  input  logic        busRw,
  input  logic [15:0] busAddr,
  output ctrlT        ctl
);
  localparam logic [7:0] OFF_CASS = 8'h20;
  localparam logic [7:0] OFF_STB  = 8'h40;
  localparam logic [4:0] GRP_ANN  = 5'b01011;  // 0x58..0x5F
  localparam logic [4:0] GRP_RD   = 5'b01100;  // 0x60..0x67
  localparam logic [7:0] OFF_PAD  = 8'h70;

  logic       hit;
  logic [7:0] lo;

  always_comb begin
    ctl = '0;
    hit = busEn && (busAddr[15:8] == PAGE);
    lo  = busAddr[7:0];
    if (hit) begin
      if (lo == OFF_CASS) ctl.cassFlip = 1'b1;
      if (lo == OFF_STB)  ctl.stbFire  = 1'b1;
      if (lo == OFF_PAD)  ctl.padFire  = 1'b1;
      if (lo[7:3] == GRP_ANN) begin
        ctl.annWe  = 1'b1;
        ctl.annIdx = lo[2:1];
        ctl.annVal = lo[0];
      end
      if (lo[7:3] == GRP_RD && busRw) begin
        ctl.rdEn  = 1'b1;
        ctl.rdSel = lo[2:0];
      end
    end
  end
endmodule

// File: rtl/gameDatapath.sv
`timescale 1ns/1ps
module gameDatapath
  import gamePkg::*;
#(
  parameter int STB_CYCLES = 61,
  parameter int TICK_DIV   = 8,
  parameter int NPAD       = 4,
  parameter int CNT_W      = 8,
  parameter int NSW        = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlT                  ctl,
  input  logic [NSW-1:0]        swIn,
  input  logic                  cassIn,
  input  logic [NPAD*CNT_W-1:0] padCount,
  output logic [3:0]            annOut,
  output logic                  stbN,
  output logic                  cassOut,
  output logic [7:0]            busRdata
);
  localparam int STB_W = $clog2(STB_CYCLES + 1);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [STB_W-1:0] STB_LOAD = STB_W'(STB_CYCLES);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [STB_W-1:0] stbCnt;
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic [NPAD-1:0]  padRun;
  logic [7:0]       statusVec;

  // Annunciators and cassette output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      annOut  <= '0;
      cassOut <= 1'b0;
    end else begin
      if (ctl.annWe)    annOut[ctl.annIdx] <= ctl.annVal;
      if (ctl.cassFlip) cassOut <= ~cassOut;
    end
  end

  // Strobe one-shot, retriggerable
  always_ff @(posedge clk) begin
    if (!rstN)            stbCnt <= '0;
    else if (ctl.stbFire) stbCnt <= STB_LOAD;
    else if (stbCnt != 0) stbCnt <= stbCnt - 1'b1;
  end
  assign stbN = (stbCnt == '0);

  // Shared tick prescaler, phase restarted by a paddle trigger
  always_ff @(posedge clk) begin
    if (!rstN || ctl.padFire) preCnt <= '0;
    else if (tick)            preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_LAST);

  // Paddle one-shots
  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    logic [CNT_W-1:0] padCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                     padCnt <= '0;
      else if (ctl.padFire)          padCnt <= padCount[i*CNT_W +: CNT_W];
      else if (tick && padCnt != 0)  padCnt <= padCnt - 1'b1;
    end
    assign padRun[i] = (padCnt != '0);
  end

  // Status selection for reads
  always_comb begin
    statusVec = '0;
    statusVec[0] = cassIn;
    statusVec[NSW:1] = swIn;
    for (int j = 0; j < NPAD; j++) statusVec[4 + j] = ~padRun[j];
  end

  assign busRdata = ctl.rdEn ? {statusVec[ctl.rdSel], 7'b0} : 8'h00;
endmodule

// File: rtl/gameIoPage.sv
`timescale 1ns/1ps
module gameIoPage
  import gamePkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int STB_WIDTH_NS  = 489,
  parameter int TICK_DIV      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busRw,
  input  logic [15:0] busAddr,
  output logic [7:0]  busRdata,
  input  logic [2:0]  swIn,
  input  logic        cassIn,
  input  logic [31:0] padCount,
  output logic [3:0]  annOut,
  output logic        stbN,
  output logic        cassOut
);
  localparam int STB_RAW    = (STB_WIDTH_NS * 1000 + CLK_PERIOD_PS / 2) / CLK_PERIOD_PS;
  localparam int STB_CYCLES = (STB_RAW < 1) ? 1 : STB_RAW;

  ctrlT ctl;

  gameDecode #(.PAGE(8'hC0)) uDecode (
    .busEn(busEn), .busRw(busRw), .busAddr(busAddr), .ctl(ctl)
  );

  gameDatapath #(
    .STB_CYCLES(STB_CYCLES), .TICK_DIV(TICK_DIV),
    .NPAD(4), .CNT_W(8), .NSW(3)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .swIn(swIn), .cassIn(cassIn),
    .padCount(padCount), .annOut(annOut), .stbN(stbN),
    .cassOut(cassOut), .busRdata(busRdata)
  );
endmodule

// File: rtl/gameIoPageChk.sv
`timescale 1ns/1ps
module gameIoPageChk (
  input logic        clk,
  input logic        rstN,
  input logic        busEn,
  input logic        busRw,
  input logic [15:0] busAddr,
  input logic [7:0]  busRdata,
  input logic [3:0]  annOut,
  input logic        stbN,
  input logic        cassOut
);
  logic inPage, annAcc, cassAcc, stbAcc;
  assign inPage  = busEn && (busAddr[15:8] == 8'hC0);
  assign annAcc  = inPage && (busAddr[7:3] == 5'b01011);
  assign cassAcc = inPage && (busAddr[7:0] == 8'h20);
  assign stbAcc  = inPage && (busAddr[7:0] == 8'h40);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (annOut == 4'h0 && stbN && !cassOut));

  p_ann_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    annAcc |=> annOut[$past(busAddr[2:1])] == $past(busAddr[0]));

  p_ann_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !annAcc |=> $stable(annOut));

  p_stb_fire_r3: assert property (@(posedge clk) disable iff (!rstN)
    stbAcc |=> !stbN);

  p_cass_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    cassAcc |=> cassOut != $past(cassOut));

  p_cass_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cassAcc |=> $stable(cassOut));

  p_low_bits_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[6:0] == 7'h00);

  p_write_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busEn || !busRw) |-> busRdata == 8'h00);
endmodule

bind gameIoPage gameIoPageChk uChk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busRw(busRw), .busAddr(busAddr),
  .busRdata(busRdata), .annOut(annOut), .stbN(stbN), .cassOut(cassOut)
);

// File: tb/gameIoPage_test.sv
`timescale 1ns/1ps
module gameIoPage_test;
  localparam int DIV = 3;
  localparam int STB = (489 * 1000 + 4000) / 8000;  // 61
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busRw = 1'b1;
  logic [15:0] busAddr = 16'h0;
  logic [7:0]  busRdata;
  logic [2:0]  swIn = 3'b0;
  logic        cassIn = 1'b0;
  logic [31:0] padCount = 32'h0;
  logic [3:0]  annOut;
  logic        stbN;
  logic        cassOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  gameIoPage #(.CLK_PERIOD_PS(8000), .STB_WIDTH_NS(489), .TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busRw(busRw), .busAddr(busAddr),
    .busRdata(busRdata), .swIn(swIn), .cassIn(cassIn), .padCount(padCount),
    .annOut(annOut), .stbN(stbN), .cassOut(cassOut)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One bus cycle starting at a negedge; read data sampled before the edge
  task automatic access(input logic [15:0] a, input logic rw, input logic en,
                        output logic [7:0] rd);
    busEn = en; busAddr = a; busRw = rw;
    #2 rd = busRdata;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  function automatic logic [7:0] padExp(input int k, input int n);
    return (k >= n * DIV) ? 8'h80 : 8'h00;
  endfunction

  task automatic pollPads(input int n0, input int n1, input int n2,
                          input int n3, input int lim);
    logic [7:0] rd;
    int cnt[4];
    cnt = '{n0, n1, n2, n3};
    for (int k = 0; k <= lim; k++) begin
      access(16'hC064 + 16'(k % 4), 1'b1, 1'b1, rd);
      check(rd == padExp(k, cnt[k % 4]), "R7", "paddle status", rd, padExp(k, cnt[k % 4]));
    end
  endtask

  initial begin
    #(MAX_CYCLES * 8);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [3:0] annModel;
    logic cassModel;
    int seed;
    int c[4];
    seed = $urandom(32'h1357);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(annOut == 4'h0, "R1", "annOut", annOut, 0);
    check(stbN == 1'b1, "R1", "stbN", stbN, 1);
    check(cassOut == 1'b0, "R1", "cassOut", cassOut, 0);
    for (int i = 0; i < 4; i++) begin
      access(16'hC064 + 16'(i), 1'b1, 1'b1, rd);
      check(rd == 8'h80, "R1", "paddle expired", rd, 8'h80);
    end

    // R5, R6 inputs
    for (int t = 0; t < 12; t++) begin
      cassIn = 1'($urandom);
      swIn = 3'($urandom);
      access(16'hC060, 1'b1, 1'b1, rd);
      check(rd == {cassIn, 7'b0}, "R5", "cassette in", rd, {cassIn, 7'b0});
      for (int s = 0; s < 3; s++) begin
        access(16'hC061 + 16'(s), 1'b1, 1'b1, rd);
        check(rd == {swIn[s], 7'b0}, "R6", "button", rd, {swIn[s], 7'b0});
      end
    end

    // R2 annunciators, random offsets and directions
    annModel = 4'h0;
    for (int t = 0; t < 40; t++) begin
      int off;
      off = int'($urandom_range(7, 0));
      access(16'hC058 + 16'(off), 1'($urandom), 1'b1, rd);
      annModel[off >> 1] = off[0];
      check(annOut == annModel, "R2", "annunciators", annOut, annModel);
    end

    // R4 cassette toggle
    cassModel = 1'b0;
    for (int t = 0; t < 6; t++) begin
      access(16'hC020, 1'($urandom), 1'b1, rd);
      cassModel = ~cassModel;
      check(cassOut == cassModel, "R4", "cassOut", cassOut, cassModel);
    end

    // R3 strobe width
    access(16'hC040, 1'b1, 1'b1, rd);
    for (int s = 1; s <= STB; s++) begin
      if (stbN !== 1'b0) check(1'b0, "R3", "stbN low", stbN, 0);
      @(negedge clk);
    end
    check(stbN == 1'b1, "R3", "stbN after width", stbN, 1);
    // R3 retrigger mid-pulse
    access(16'hC040, 1'b0, 1'b1, rd);
    repeat (20) @(negedge clk);
    access(16'hC040, 1'b1, 1'b1, rd);
    for (int s = 1; s <= STB; s++) begin
      if (stbN !== 1'b0) check(1'b0, "R3", "stbN low after retrigger", stbN, 0);
      @(negedge clk);
    end
    check(stbN == 1'b1, "R3", "stbN end after retrigger", stbN, 1);

    // R7 paddle timing, random counts, one zero
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 4; i++) c[i] = int'($urandom_range(40, 1));
      if (t == 1) c[2] = 0;
      if (t == 2) c[0] = 255;
      padCount = {8'(c[3]), 8'(c[2]), 8'(c[1]), 8'(c[0])};
      access(16'hC070, 1'($urandom), 1'b1, rd);
      pollPads(c[0], c[1], c[2], c[3], 256 * DIV + 4);
    end

    // R8 retrigger while running
    padCount = {8'd30, 8'd30, 8'd30, 8'd30};
    access(16'hC070, 1'b1, 1'b1, rd);
    repeat (25) @(negedge clk);
    c = '{7, 12, 3, 20};
    padCount = {8'd20, 8'd3, 8'd12, 8'd7};
    access(16'hC070, 1'b1, 1'b1, rd);
    for (int k = 0; k <= 20 * DIV + 2; k++) begin
      access(16'hC064 + 16'(k % 4), 1'b1, 1'b1, rd);
      check(rd == padExp(k, c[k % 4]), "R8", "reloaded paddle", rd, padExp(k, c[k % 4]));
    end

    // R9 zero read data for writes, idle and unmapped offsets
    access(16'hC061, 1'b0, 1'b1, rd);
    check(rd == 8'h00, "R9", "write returns zero", rd, 0);
    access(16'hC000, 1'b1, 1'b1, rd);
    check(rd == 8'h00, "R9", "unmapped C000", rd, 0);
    access(16'hC068, 1'b1, 1'b1, rd);
    check(rd == 8'h00, "R9", "unmapped C068", rd, 0);
    access(16'hC071, 1'b1, 1'b1, rd);
    check(rd == 8'h00, "R9", "unmapped C071", rd, 0);

    // R10 ignored accesses
    annModel = annOut;
    cassModel = cassOut;
    access(16'hD059 ^ 16'({annModel[0], 1'b0} & 2'b0), 1'b1, 1'b1, rd);
    access(16'hC059, 1'b1, 1'b0, rd);
    access(16'hC058, 1'b0, 1'b0, rd);
    access(16'hD020, 1'b1, 1'b1, rd);
    access(16'hC020, 1'b1, 1'b0, rd);
    access(16'hC040, 1'b1, 1'b0, rd);
    access(16'h4070, 1'b1, 1'b1, rd);
    check(annOut == annModel, "R10", "annunciators untouched", annOut, annModel);
    check(cassOut == cassModel, "R10", "cassette untouched", cassOut, cassModel);
    check(stbN == 1'b1, "R10", "no strobe", stbN, 1);
    access(16'hC065, 1'b1, 1'b1, rd);
    check(rd == 8'h80, "R10", "paddle not retriggered", rd, 8'h80);
    access(16'hC160, 1'b1, 1'b1, rd);
    check(rd == 8'h00, "R10", "read outside page", rd, 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule